// File: doc/BRIEF.md
# Serial Memory Bus Slave Front-End

This block is the bus-side protocol engine of a 256-byte serial memory on a two-wire bus. It oversamples the SCL and SDA lines with the system clock and finds the bus conditions in them: START, repeated START and STOP. It collects bits into bytes and checks the first byte of each transaction against a fixed 7-bit identifier. Its only output onto the bus is an open-drain enable for SDA. It uses that enable to acknowledge bytes and to send read data. The command sequencer behind it gets one-cycle events: a byte received, a read byte needed, and a STOP.

The program-cycle controller raises a busy input while the memory array is being written. During that time the front-end ignores the bus completely, and that includes START. A master can therefore poll by sending a device select until it is acknowledged. The sequencer supplies each read byte on a data input. It has from the read-request pulse until the falling SCL edge that ends the ninth bit to provide it.

Top module: `i2cs_front`

## Requirements
- R1: The block takes part in a transaction only after a START, which is SDA falling while SCL is high. Clocking bytes with no START before them gives no acknowledge and no event.
- R2: A STOP is SDA rising while SCL is high. It returns the block to idle. If a device select was matched since the last START, `stop_o` pulses for one clock.
- R3: The device select byte is shifted in MSB first on SCL rising edges. If its upper seven bits equal 1010000, `sda_oe_o` is high while SCL is high in the ninth clock. On any other value there is no acknowledge, and the block stays idle until the next START.
- R4: After a write select (bit 0 = 0), every data byte is shown on `rx_byte_o` with a one-clock `byte_valid_o` pulse after its eighth SCL rise, and is then acknowledged in the ninth clock. `rx_first_o` is 1 only for the first byte after the select.
- R5: A read select (bit 0 = 1) pulses `read_req_o` after its eighth SCL rise. `tx_data_i` is captured at the SCL fall that ends the ninth clock and sent MSB first. A 0 bit drives `sda_oe_o` high and a 1 bit releases the line.
- R6: After a read byte, the master's ninth bit decides what happens next. If it is low (ack), `read_req_o` pulses and another byte follows. If it is high (nack), the line stays released and no further byte or request is produced until the next START.
- R7: A repeated START in the middle of a byte drops the partial byte. The next eight bits are treated as a new device select.
- R8: While `busy_i` is high there is no acknowledge, no event and no START detection. After `busy_i` falls, a new START is needed before the block responds.
- R9: `sda_oe_o` never changes while SCL is high. It changes only after a falling SCL edge.
- R10: Under reset `sda_oe_o`, `byte_valid_o`, `read_req_o` and `stop_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| busy_i | input | 1 | Program cycle running; bus is ignored |
| tx_data_i | input | 8 | Next read byte from the sequencer |
| sda_oe_o | output | 1 | Pull SDA low when high |
| rx_byte_o | output | 8 | Last received data byte |
| rx_first_o | output | 1 | Byte on rx_byte_o is the first after a write select |
| byte_valid_o | output | 1 | One-clock pulse: rx_byte_o updated |
| read_req_o | output | 1 | One-clock pulse: supply next tx_data_i |
| stop_o | output | 1 | One-clock pulse: STOP ended a selected transaction |

## Verification
Select bytes are tried in three forms: the exact identifier with write, the same identifier with read, and an identifier with one low bit flipped. Together these separate the compare from the direction bit. Write frames carry bytes with several mixed bit patterns, so a wrong shift direction or a lost bit shows in `rx_byte_o`. Read frames send patterns with zeros at both ends and end with an ack and then a nack, which shows whether the block keeps sending or lets go of the line. The same select byte is also sent in three other situations: with no START before it, while busy, and after a repeated START that cuts a byte short. This tells apart a block that really needs START from one that merely counts bits.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-2:0] DEV_ID = 7'b1010000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ACK,
    ST_WRBYTE,
    ST_RDBYTE,
    ST_RDACK
  } fe_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  // reset high: idle bus level, no false edge at release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '1;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '1;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;

  AST_COND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({scl_rise_o, scl_fall_o, start_o, stop_o}) <= 1); // R1
endmodule

// File: rtl/i2cs_front.sv
module i2cs_front
  import i2cs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_first_o,
  output logic              byte_valid_o,
  output logic              read_req_o,
  output logic              stop_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [1:0] bus_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2cs_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  fe_state_e        state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic rw_q, id_ok_q, sel_q, first_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      shreg_q      <= '0;
      rw_q         <= 1'b0;
      id_ok_q      <= 1'b0;
      sel_q        <= 1'b0;
      first_q      <= 1'b0;
      mack_q       <= 1'b0;
      sda_oe_o     <= 1'b0;
      rx_byte_o    <= '0;
      rx_first_o   <= 1'b0;
      byte_valid_o <= 1'b0;
      read_req_o   <= 1'b0;
      stop_o       <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      read_req_o   <= 1'b0;
      stop_o       <= 1'b0;
      if (busy_i) begin
        // deaf during program cycle; release only on a low SCL
        state_q   <= ST_IDLE;
        sel_q     <= 1'b0;
        bit_cnt_q <= '0;
        if (scl_fall) sda_oe_o <= 1'b0;
      end else if (start_det) begin
        state_q   <= ST_DEVSEL;
        bit_cnt_q <= '0;
        sel_q     <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        stop_o  <= sel_q;
        sel_q   <= 1'b0;
      end else begin
        if (scl_rise) begin
          unique case (state_q)
            ST_DEVSEL, ST_WRBYTE: begin
              if (bit_cnt_q != CNT_FULL) begin
                shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == CNT_LAST) begin
                  if (state_q == ST_DEVSEL) begin
                    id_ok_q    <= (shreg_q[BYTE_W-2:0] == DEV_ID);
                    rw_q       <= sda_s;
                    read_req_o <= (shreg_q[BYTE_W-2:0] == DEV_ID) && sda_s;
                  end else begin
                    byte_valid_o <= 1'b1;
                    rx_byte_o    <= {shreg_q[BYTE_W-2:0], sda_s};
                    rx_first_o   <= first_q;
                    first_q      <= 1'b0;
                  end
                end
              end
            end
            ST_RDBYTE: begin
              if (bit_cnt_q != CNT_FULL) bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            ST_RDACK: begin
              if (!sda_s) begin
                read_req_o <= 1'b1;
                mack_q     <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
        if (scl_fall) begin
          unique case (state_q)
            ST_DEVSEL: begin
              if (bit_cnt_q == CNT_FULL) begin
                if (id_ok_q) begin
                  state_q  <= ST_ACK;
                  sda_oe_o <= 1'b1;
                  sel_q    <= 1'b1;
                  first_q  <= ~rw_q;
                end else begin
                  state_q  <= ST_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end
            end
            ST_WRBYTE: begin
              if (bit_cnt_q == CNT_FULL) begin
                state_q  <= ST_ACK;
                sda_oe_o <= 1'b1;
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
            ST_ACK: begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                state_q  <= ST_RDBYTE;
                shreg_q  <= tx_data_i;
                sda_oe_o <= ~tx_data_i[BYTE_W-1];
              end else begin
                state_q  <= ST_WRBYTE;
                sda_oe_o <= 1'b0;
              end
            end
            ST_RDBYTE: begin
              if (bit_cnt_q == CNT_FULL) begin
                state_q  <= ST_RDACK;
                sda_oe_o <= 1'b0;
                mack_q   <= 1'b0;
              end else begin
                shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~shreg_q[BYTE_W-2];
              end
            end
            ST_RDACK: begin
              if (mack_q) begin
                state_q   <= ST_RDBYTE;
                bit_cnt_q <= '0;
                shreg_q   <= tx_data_i;
                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
              end
            end
            default: sda_oe_o <= 1'b0;
          endcase
        end
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s)); // R9
  AST_BUSY_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(byte_valid_o || read_req_o || stop_o)); // R8
  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, read_req_o, stop_o})); // R4
  AST_BYTE_ON_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> (state_q == ST_WRBYTE) && (bit_cnt_q == CNT_FULL)); // R4
  AST_DEVSEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEVSEL) |-> !sda_oe_o); // R3
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && !$past(start_det) |-> !read_req_o || $past(state_q) == ST_RDACK); // R6
endmodule

// File: tb/i2cs_front_bench.sv
module i2cs_front_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam logic [1:0] EV_BYTE = 2'd1, EV_REQ = 2'd2, EV_STOP = 2'd3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic sda_oe_o, rx_first_o, byte_valid_o, read_req_o, stop_o;
  logic [7:0] rx_byte_o;
  logic sda_line;

  int checks = 0, failures = 0, r9_viol = 0;
  string cur_req = "R1";
  logic [10:0] exp_q[$];
  logic [7:0]  rd_src[$];
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;
  assign sda_line = sda_m & ~sda_oe_o;

  i2cs_front u_i2cs_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .busy_i      (busy_i),
    .tx_data_i   (tx_data_i),
    .sda_oe_o    (sda_oe_o),
    .rx_byte_o   (rx_byte_o),
    .rx_first_o  (rx_first_o),
    .byte_valid_o(byte_valid_o),
    .read_req_o  (read_req_o),
    .stop_o      (stop_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pops expected events as the design emits them
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (scl_m && scl_prev && (sda_oe_o != oe_prev)) r9_viol++;
      scl_prev <= scl_m;
      oe_prev  <= sda_oe_o;
      if (byte_valid_o || read_req_o || stop_o) begin
        logic [10:0] got;
        got = byte_valid_o ? {EV_BYTE, rx_first_o, rx_byte_o} :
              read_req_o   ? {EV_REQ, 9'd0} : {EV_STOP, 9'd0};
        if (exp_q.size() == 0) chk(1'b0, cur_req, 32'(got), 32'h0);
        else begin
          logic [10:0] want;
          want = exp_q.pop_front();
          chk(got == want, cur_req, 32'(got), 32'(want));
        end
        if (read_req_o) tx_data_i <= (rd_src.size() != 0) ? rd_src.pop_front() : 8'hxx;
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  task automatic push_byte(input logic first, input logic [7:0] b);
    exp_q.push_back({EV_BYTE, first, b});
  endtask

  task automatic finish_run();
    chk(exp_q.size() == 0, "R4", 32'(exp_q.size()), 32'h0);
    chk(r9_viol == 0, "R9", 32'(r9_viol), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(4);
    cur_req = "R10";
    chk({sda_oe_o, byte_valid_o, read_req_o, stop_o} == 4'b0, "R10",
        {sda_oe_o, byte_valid_o, read_req_o, stop_o}, 4'b0);
    rst_ni = 1'b1; tick(4);

    // R1: bytes clocked without START
    cur_req = "R1";
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA0, a); chk(!a, "R1", a, 0);
    send_byte(8'h5A, a); chk(!a, "R1", a, 0);
    scl_m = 1'b1; tick(Q);

    // R3/R4/R2: write frame
    cur_req = "R4";
    bus_start();
    send_byte(8'hA0, a); chk(a, "R3", a, 1);
    push_byte(1'b1, 8'h3C);
    send_byte(8'h3C, a); chk(a, "R4", a, 1);
    push_byte(1'b0, 8'h81);
    send_byte(8'h81, a); chk(a, "R4", a, 1);
    exp_q.push_back({EV_STOP, 9'd0});
    cur_req = "R2";
    bus_stop();

    // R3: wrong identifier, no ack, no events, no stop report
    cur_req = "R3";
    bus_start();
    send_byte(8'hA2, a); chk(!a, "R3", a, 0);
    send_byte(8'h11, a); chk(!a, "R3", a, 0);
    bus_stop();

    // R5/R6: read frame, ack then nack
    cur_req = "R5";
    bus_start();
    exp_q.push_back({EV_REQ, 9'd0}); rd_src.push_back(8'hC5);
    send_byte(8'hA1, a); chk(a, "R3", a, 1);
    exp_q.push_back({EV_REQ, 9'd0}); rd_src.push_back(8'h6E);
    recv_byte(1'b1, d); chk(d == 8'hC5, "R5", d, 8'hC5);
    cur_req = "R6";
    recv_byte(1'b0, d); chk(d == 8'h6E, "R6", d, 8'h6E);
    recv_byte(1'b1, d); chk(d == 8'hFF, "R6", d, 8'hFF);
    exp_q.push_back({EV_STOP, 9'd0});
    bus_stop();

    // R7: repeated START cuts a byte short
    cur_req = "R7";
    bus_start();
    send_byte(8'hA0, a); chk(a, "R3", a, 1);
    push_byte(1'b1, 8'h10);
    send_byte(8'h10, a); chk(a, "R4", a, 1);
    clk_bit(1'b0, a); clk_bit(1'b1, a); clk_bit(1'b1, a);
    bus_start();
    send_byte(8'hA0, a); chk(a, "R7", a, 1);
    push_byte(1'b1, 8'h77);
    send_byte(8'h77, a); chk(a, "R7", a, 1);
    // random read after repeated START
    bus_start();
    exp_q.push_back({EV_REQ, 9'd0}); rd_src.push_back(8'h02);
    send_byte(8'hA1, a); chk(a, "R7", a, 1);
    recv_byte(1'b0, d); chk(d == 8'h02, "R5", d, 8'h02);
    exp_q.push_back({EV_STOP, 9'd0});
    bus_stop();

    // R8: busy makes the block deaf, including to START
    cur_req = "R8";
    busy_i = 1'b1; tick(2);
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R8", a, 0);
    send_byte(8'h55, a); chk(!a, "R8", a, 0);
    busy_i = 1'b0; tick(Q);
    send_byte(8'hA0, a); chk(!a, "R8", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA0, a); chk(a, "R8", a, 1);
    exp_q.push_back({EV_STOP, 9'd0});
    bus_stop();
    tick(Q);
    finish_run();
  end
endmodule